// File: doc/BRIEF.md
# Sensor Row Dark-Level Corrector

This block takes a full frame from an external image sensor, one row at a time, and removes the dark-level offset from each row before the host sees the pixels. Each row arrives over a valid/ready handshake as `COLS + 2` signed samples. The first `COLS` samples are active pixels. The last two come from optically masked cells, so they measure only the dark level.

After a row has arrived, the engine averages the two masked samples into a per-row bias. It then subtracts that bias from every active pixel of the row and moves on to the next row. The corrected frame stays in an internal buffer. A host reads it over a simple memory-mapped port, one byte per address in row-major order.

A pulse on `start` begins a frame. `busy` stays high until the last row has been corrected. A new `start` after that captures a fresh frame over the old one.

Top module: `zero_bias_row_fix`

## Requirements
- R1: After reset, `busy` and `pix_ready` are both low.
- R2: A `start` pulse while `busy` is low raises `busy` on the next cycle and sets row and column to zero. `pix_ready` is high only while a row is being taken in.
- R3: Each row accepts exactly `COLS + 2` samples on cycles where `pix_valid` and `pix_ready` are both high. Sample positions 0 to `COLS-1` are active pixels. Positions `COLS` and `COLS+1` are the two masked samples. `pix_ready` is low on the cycle after the last masked sample is accepted.
- R4: The row bias is the 9-bit signed sum of the two masked samples, shifted right arithmetically by one (floor division by 2). For example, masked values -3 and 0 give a bias of -2.
- R5: Each stored pixel equals the active sample minus the row bias, kept modulo 256 as a signed 8-bit value. For example, 127 minus a bias of -128 is stored as 0xFF.
- R6: Each row is corrected with its own bias and no other.
- R7: After the last of `ROWS` rows is corrected, `busy` falls and the engine returns to idle.
- R8: A `start` pulse while `busy` is high has no effect on the frame in progress.
- R9: A read with `rd_en` high at address `row*COLS + col` returns the corrected pixel on `rd_data` one cycle later. Data is valid once `busy` has fallen.
- R10: Samples presented on `pix_valid` while `pix_ready` is low are not taken and do not change the stored image.
- R11: A second frame started after the first one completes replaces the whole buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin capture of one frame |
| pix_valid | input | 1 | Sensor sample present |
| pix_data | input | 8 | Signed sensor sample |
| pix_ready | output | 1 | Engine accepts a sample this cycle |
| busy | output | 1 | Frame capture or correction in progress |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 12 | Host read address, row-major |
| rd_data | output | 8 | Read data, one cycle after the strobe |

## Verification
The first frame uses arithmetic ramps as active pixels and a masked pair that changes from row to row. A row-sharing or stale bias would therefore show up as miscompares in whole rows. Dedicated rows use a negative odd masked sum, which separates floor from truncation, and extreme masked values that force the subtraction to wrap. The same frame also carries a stray `start` partway through and junk samples offered while the engine is correcting. Any restart or unintended write would corrupt later rows. A second frame built from a different pattern confirms that every address is rewritten and that row-major addressing holds.

// File: rtl/zero_bias_row_fix.sv
module zero_bias_row_fix #(
  parameter int ROWS = 64,
  parameter int COLS = 64,
  parameter int DW   = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic                                  pix_valid,
  input  logic [DW-1:0]                         pix_data,
  output logic                                  pix_ready,
  output logic                                  busy,
  input  logic                                  rd_en,
  input  logic [$clog2(ROWS)+$clog2(COLS)-1:0]  rd_addr,
  output logic [DW-1:0]                         rd_data
);
  localparam int SPR = COLS + 2;
  localparam int CW  = $clog2(SPR);
  localparam int RW  = $clog2(ROWS);
  localparam int XW  = $clog2(COLS);
  localparam int AW  = RW + XW;

  typedef enum logic [2:0] {S_IDLE, S_GET, S_BIAS, S_FIX, S_NEXT} st_t;

  st_t                 state;
  logic [RW-1:0]       row;
  logic [CW-1:0]       col;
  logic [DW-1:0]       dark0, dark1, bias;
  logic signed [DW:0]  dsum;
  logic [DW-1:0]       img [ROWS*COLS];

  wire [AW-1:0] wr_idx = {row, col[XW-1:0]};
  wire          take   = pix_valid && pix_ready;

  assign dsum      = $signed({dark0[DW-1], dark0}) + $signed({dark1[DW-1], dark1});
  assign pix_ready = (state == S_GET);
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (take && col < CW'(COLS))
      img[wr_idx] <= pix_data;
    else if (state == S_FIX)
      img[wr_idx] <= img[wr_idx] - bias;
    if (rd_en)
      rd_data <= img[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      row   <= '0;
      col   <= '0;
      dark0 <= '0;
      dark1 <= '0;
      bias  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          row   <= '0;
          col   <= '0;
          state <= S_GET;
        end
        S_GET: if (take) begin
          if (col == CW'(COLS))     dark0 <= pix_data;
          if (col == CW'(COLS + 1)) begin
            dark1 <= pix_data;
            state <= S_BIAS;
          end
          col <= col + 1'b1;
        end
        S_BIAS: begin
          bias  <= DW'(dsum >>> 1);
          col   <= '0;
          state <= S_FIX;
        end
        S_FIX: begin
          col <= col + 1'b1;
          if (col == CW'(COLS - 1)) state <= S_NEXT;
        end
        S_NEXT: begin
          col <= '0;
          if (row == RW'(ROWS - 1)) state <= S_IDLE;
          else begin
            row   <= row + 1'b1;
            state <= S_GET;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_ready_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy);
  assert_start_launches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && row == '0 && col == '0));
  assert_col_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    col <= CW'(SPR));
  assert_ready_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && col == CW'(COLS + 1)) |=> !pix_ready);
  assert_bias_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIX && $past(state) == S_FIX) |-> $stable(bias));
  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(row) == RW'(ROWS - 1));
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != S_NEXT) |=> $stable(row));
endmodule

// File: tb/sim_zero_bias_row_fix.sv
module sim_zero_bias_row_fix;
  localparam int ROWS = 64;
  localparam int COLS = 64;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic        pix_valid = 0;
  logic [7:0]  pix_data = 0;
  logic        pix_ready, busy;
  logic        rd_en = 0;
  logic [11:0] rd_addr = 0;
  logic [7:0]  rd_data;

  int applied = 0;
  int errors  = 0;
  logic [7:0] expq [$];

  always #2.5 clk = ~clk;

  zero_bias_row_fix #(.ROWS(ROWS), .COLS(COLS), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_data(pix_data), .pix_ready(pix_ready), .busy(busy),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data));

  task automatic check(input string req, input int act, input int exp);
    applied++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_of(int img, int r, int c);
    if (img == 0) return 8'((r * 7 + c * 13) & 255);
    return 8'(((r * c + r) ^ 8'h5A) & 255);
  endfunction

  function automatic logic [7:0] dark_of(int img, int r, int k);
    if (r == 1) return (k == 0) ? 8'hFD : 8'h00;
    if (r == 2) return 8'h80;
    if (r == 3) return 8'h7F;
    if (img == 0) return (k == 0) ? 8'(r * 37) : 8'(r * 91 + 5);
    return (k == 0) ? 8'(200 - r * 3) : 8'(r * 11);
  endfunction

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    pix_data  = d;
    pix_valid = 1;
    while (!pix_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic drive_frame(input int img, input bit stray);
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check("R2 busy after start", busy, 1);
    for (int r = 0; r < ROWS; r++) begin
      int s;
      int b;
      for (int c = 0; c < COLS; c++) send(pix_of(img, r, c));
      send(dark_of(img, r, 0));
      send(dark_of(img, r, 1));
      @(negedge clk);
      pix_valid = 0;
      if (r == 0) check("R3 ready low after masked pair", pix_ready, 0);
      if (stray && r == 5) begin
        pix_valid = 1;
        pix_data  = 8'hEE;
        repeat (10) @(negedge clk);
        pix_valid = 0;
      end
      if (stray && r == 10) begin
        start = 1;
        @(negedge clk);
        start = 0;
      end
      s = int'($signed(dark_of(img, r, 0))) + int'($signed(dark_of(img, r, 1)));
      b = s >>> 1;
      if (r == 1) check("R4 floor of negative odd sum", b, -2);
      for (int c = 0; c < COLS; c++)
        expq.push_back(8'((int'(pix_of(img, r, c)) - b) & 255));
    end
  endtask

  task automatic read_frame(input string tag);
    int guard = 0;
    while (busy && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check("R7 busy falls after last row", busy, 0);
    check("R1 ready low when idle", pix_ready, 0);
    for (int a = 0; a < ROWS * COLS; a++) begin
      logic [7:0] e;
      string req;
      rd_en   = 1;
      rd_addr = 12'(a);
      @(negedge clk);
      rd_en = 0;
      e = expq.pop_front();
      if (a / COLS == 1)                 req = "R4";
      else if (a / COLS == 2 || a / COLS == 3) req = "R5 wrap";
      else if (a / COLS > 5)             req = "R6 R8 R10";
      else                               req = "R5";
      req = {req, " R9 ", tag};
      check(req, rd_data, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy at reset", busy, 0);
    check("R1 ready at reset", pix_ready, 0);
    rst_n = 1;
    @(negedge clk);
    drive_frame(0, 1);
    read_frame("frame1");
    drive_frame(1, 0);
    read_frame("R11 frame2");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end
endmodule